// File: doc/BRIEF.md
# SDRAM Burst Read Cycle Sequencer

This block steps a synchronous DRAM through one complete burst read. A read starts with a request that carries a line address and a flag. The flag says whether the read is a cache-line fill or a DMA transfer. The block then drives these cycles in order:

- the row activation;
- an optional extra cycle for the RAS-to-CAS delay;
- the read command with auto-precharge;
- the CAS-latency wait;
- eight half-word data cycles;
- the precharge recovery.

It ends with a one-cycle completion pulse.

The delay between activation and read is set per request. So are the CAS latency, which is chosen for one of two chip-select spaces, and the precharge recovery time. The block latches these settings when it accepts the request and uses them for the whole burst. The CAS latency can be set to 4 cycles, one more than the memory needs, so that a pipeline latch can sit between the memory and the data capture. During the data cycles the low column bits step through the 16-byte line. A cache fill starts two half-words past the missed word and wraps around the line.

Top module: `sdr_burst_seq`

## Requirements
- R1: A request is taken only when the block is idle, on the clock edge where `startReq` is high. The cycle after that edge drives the activate command for one cycle. Command codes: 2'b00 no-op, 2'b01 activate, 2'b10 read with auto-precharge. `rowAddr` shows `lineAddr[20:9]` from that cycle until done.
- R2: With `rcdSel`=0 the read command directly follows the activate cycle. With `rcdSel`=1 there is exactly one no-op cycle between them.
- R3: The CAS latency comes from `casLatA` when `csSel`=0 and from `casLatB` when `csSel`=1. Field values 00, 01, 10 and 11 mean 1, 2, 3 and 4 cycles. The first data cycle comes that many cycles after the read command, and the cycles in between carry no-op.
- R4: There are exactly eight consecutive data cycles. `dataStrobe` and `busStart` are both high in every one of them and low in every other cycle.
- R5: The precharge wait follows the last data cycle. With a CAS latency of 1 it lasts 1 cycle when `trpSel`=0 and 2 cycles when `trpSel`=1. With a CAS latency of 2 or more it lasts 0 or 1 cycle for `trpSel`=0 or 1. Every cycle after the read command carries no-op.
- R6: From the read command through the last data cycle, `colAddr` equals {`lineAddr[8:4]`, beat, 1'b0}. The 3-bit beat holds its start value up to the first data cycle. It then rises by one each data cycle, wrapping modulo 8.
- R7: A DMA burst (`fillMode`=0) starts at beat 0, whatever the low request bits are. A cache fill (`fillMode`=1) starts at beat (`lineAddr[3:1]` + 2) mod 8.
- R8: `done` is high for exactly one cycle, right after the last precharge-wait cycle, or right after the last data cycle when the wait is zero. The cycle after that is idle.
- R9: A request raised while a burst runs, including during the done cycle, is ignored. Changes to any configuration or address input after acceptance do not alter the running burst.
- R10: During and right after reset the command is no-op and `busStart`, `dataStrobe` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Burst request |
| lineAddr | input | 21 | Request byte address (row, column, in-line offset) |
| fillMode | input | 1 | 1 = cache-line fill order, 0 = DMA ascending order |
| csSel | input | 1 | Chip-select space choosing the CAS latency field |
| rcdSel | input | 1 | RAS-to-CAS delay: 0 = one cycle, 1 = two cycles |
| casLatA | input | 2 | CAS latency field for space 0 |
| casLatB | input | 2 | CAS latency field for space 1 |
| trpSel | input | 1 | Precharge recovery setting |
| cmd | output | 2 | Memory command |
| rowAddr | output | 12 | Row address |
| colAddr | output | 9 | Column address with stepping beat bits |
| busStart | output | 1 | Bus-start strobe, high in each data cycle |
| dataStrobe | output | 1 | Read-data capture strobe |
| done | output | 1 | One-cycle burst completion pulse |

## Verification
Two functions can fall in the same cycle: a new request, and the end of the running burst. This happens when `startReq` is held high through the done cycle. Random and directed bursts keep the request high until done shows. The bench then requires the next cycle to be idle, with no activate command. In the same bursts the bench also scrambles every configuration and address input after acceptance. Each cycle is compared with a timeline computed from the latched settings. This judges that the beat wrap and the precharge-wait length stay tied to the request as it was accepted.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_ACTV  = 2'b01,
    CMD_READA = 2'b10
  } cmdE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCDW,
    ST_RD,
    ST_CASW,
    ST_DATA,
    ST_PRE,
    ST_DONE
  } seqStateE;

  // strobes from the sequencer to the address path
  typedef struct packed {
    logic load;
    logic step;
  } dpStrobeT;

endpackage

// File: rtl/sdr_burst_addr.sv
module sdr_burst_addr
  import sdr_burst_pkg::*;
#(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 9,
  parameter int DATA_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int SKIP_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobeT                 strobe,
  input  logic [ROW_W+COL_W-1:0]   lineAddr,
  input  logic                     fillMode,
  output logic [ROW_W-1:0]         rowAddr,
  output logic [COL_W-1:0]         colAddr
);

  localparam int BYTE_W     = $clog2(DATA_W / 8);
  localparam int LINE_OFS_W = $clog2(LINE_BYTES);
  localparam int BEAT_W     = LINE_OFS_W - BYTE_W;
  localparam int BASE_W     = COL_W - LINE_OFS_W;
  localparam int SKIP_BEATS = SKIP_BYTES / (DATA_W / 8);

  logic [ROW_W-1:0]  rowQ;
  logic [BASE_W-1:0] baseQ;
  logic [BEAT_W-1:0] beatQ;
  logic [BEAT_W-1:0] missBeat;
  logic [BEAT_W-1:0] startBeat;
  logic              unusedByteBits;

  assign missBeat       = lineAddr[LINE_OFS_W-1:BYTE_W];
  assign unusedByteBits = ^lineAddr[BYTE_W-1:0];

  // fill resumes past the missed word; DMA runs from the line base
  assign startBeat = fillMode ? BEAT_W'(missBeat + BEAT_W'(SKIP_BEATS))
                              : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ  <= '0;
      baseQ <= '0;
      beatQ <= '0;
    end else if (strobe.load) begin
      rowQ  <= lineAddr[ROW_W+COL_W-1:COL_W];
      baseQ <= lineAddr[COL_W-1:LINE_OFS_W];
      beatQ <= startBeat;
    end else if (strobe.step) begin
      beatQ <= beatQ + 1'b1;
    end
  end

  assign rowAddr = rowQ;
  assign colAddr = {baseQ, beatQ, {BYTE_W{1'b0}}};

endmodule

// File: rtl/sdr_burst_ctrl.sv
module sdr_burst_ctrl
  import sdr_burst_pkg::*;
#(
  parameter int BEATS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       csSel,
  input  logic       rcdSel,
  input  logic [1:0] casLatA,
  input  logic [1:0] casLatB,
  input  logic       trpSel,
  output dpStrobeT   strobe,
  output cmdE        cmd,
  output logic       busStart,
  output logic       dataStrobe,
  output logic       done
);

  localparam int CNT_W = ($clog2(BEATS) < 3) ? 3 : $clog2(BEATS);

  seqStateE          stateQ, stateD;
  logic [CNT_W-1:0]  cntQ, cntD;
  logic              rcdQ;
  logic [1:0]        clQ;      // latency minus one
  logic [1:0]        tapQ;     // precharge-wait cycles
  logic              accept;
  logic [1:0]        clSel;
  logic [1:0]        tapSel;

  assign accept = (stateQ == ST_IDLE) && startReq;
  assign clSel  = csSel ? casLatB : casLatA;

  always_comb begin
    if (clSel == 2'd0) tapSel = trpSel ? 2'd2 : 2'd1;
    else               tapSel = trpSel ? 2'd1 : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rcdQ <= 1'b0;
      clQ  <= '0;
      tapQ <= '0;
    end else if (accept) begin
      rcdQ <= rcdSel;
      clQ  <= clSel;
      tapQ <= tapSel;
    end
  end

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    unique case (stateQ)
      ST_IDLE: if (startReq) stateD = ST_ACT;
      ST_ACT:  stateD = rcdQ ? ST_RCDW : ST_RD;
      ST_RCDW: stateD = ST_RD;
      ST_RD: begin
        if (clQ == 2'd0) begin
          stateD = ST_DATA;
          cntD   = '0;
        end else begin
          stateD = ST_CASW;
          cntD   = CNT_W'(clQ);
        end
      end
      ST_CASW: begin
        if (cntQ == CNT_W'(1)) begin
          stateD = ST_DATA;
          cntD   = '0;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_DATA: begin
        if (cntQ == CNT_W'(BEATS - 1)) begin
          if (tapQ == 2'd0) begin
            stateD = ST_DONE;
          end else begin
            stateD = ST_PRE;
            cntD   = CNT_W'(tapQ);
          end
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_PRE: begin
        if (cntQ == CNT_W'(1)) stateD = ST_DONE;
        else                   cntD   = cntQ - 1'b1;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  always_comb begin
    unique case (stateQ)
      ST_ACT:  cmd = CMD_ACTV;
      ST_RD:   cmd = CMD_READA;
      default: cmd = CMD_NOP;
    endcase
  end

  assign dataStrobe  = (stateQ == ST_DATA);
  assign busStart    = (stateQ == ST_DATA);
  assign done        = (stateQ == ST_DONE);
  assign strobe.load = accept;
  assign strobe.step = (stateQ == ST_DATA);

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_burst_pkg::*;
#(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 9,
  parameter int DATA_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int SKIP_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startReq,
  input  logic [ROW_W+COL_W-1:0] lineAddr,
  input  logic                   fillMode,
  input  logic                   csSel,
  input  logic                   rcdSel,
  input  logic [1:0]             casLatA,
  input  logic [1:0]             casLatB,
  input  logic                   trpSel,
  output logic [1:0]             cmd,
  output logic [ROW_W-1:0]       rowAddr,
  output logic [COL_W-1:0]       colAddr,
  output logic                   busStart,
  output logic                   dataStrobe,
  output logic                   done
);

  localparam int BEATS = LINE_BYTES / (DATA_W / 8);

  dpStrobeT strobe;
  cmdE      cmdInt;

  sdr_burst_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .csSel      (csSel),
    .rcdSel     (rcdSel),
    .casLatA    (casLatA),
    .casLatB    (casLatB),
    .trpSel     (trpSel),
    .strobe     (strobe),
    .cmd        (cmdInt),
    .busStart   (busStart),
    .dataStrobe (dataStrobe),
    .done       (done)
  );

  sdr_burst_addr #(
    .ROW_W      (ROW_W),
    .COL_W      (COL_W),
    .DATA_W     (DATA_W),
    .LINE_BYTES (LINE_BYTES),
    .SKIP_BYTES (SKIP_BYTES)
  ) u_addr (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lineAddr (lineAddr),
    .fillMode (fillMode),
    .rowAddr  (rowAddr),
    .colAddr  (colAddr)
  );

  assign cmd = cmdInt;

endmodule

// File: rtl/sdr_burst_chk.sv
module sdr_burst_chk #(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 9,
  parameter int DATA_W     = 16,
  parameter int LINE_BYTES = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       cmd,
  input logic [ROW_W-1:0] rowAddr,
  input logic [COL_W-1:0] colAddr,
  input logic             busStart,
  input logic             dataStrobe,
  input logic             done
);
  localparam int BYTE_W     = $clog2(DATA_W / 8);
  localparam int LINE_OFS_W = $clog2(LINE_BYTES);

  AST_ACTV_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmd == 2'b01 |=> cmd != 2'b01); // R1

  AST_BS_WITH_DATA: assert property (@(posedge clk) disable iff (!rstN)
    dataStrobe |-> busStart); // R4

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    dataStrobe && $past(dataStrobe) |->
      colAddr[LINE_OFS_W-1:BYTE_W] == $past(colAddr[LINE_OFS_W-1:BYTE_W]) + 1'b1); // R6

  AST_COL_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    dataStrobe && $past(dataStrobe) |->
      $stable(colAddr[COL_W-1:LINE_OFS_W]) && colAddr[BYTE_W-1:0] == '0); // R6

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    dataStrobe |-> $stable(rowAddr)); // R9

  AST_PRE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataStrobe) |-> cmd == 2'b00); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && cmd == 2'b00); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cmd == 2'b00 && !dataStrobe && !busStart); // R8

endmodule

bind sdr_burst_seq sdr_burst_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .rowAddr(rowAddr), .colAddr(colAddr),
  .busStart(busStart), .dataStrobe(dataStrobe), .done(done)
);

// File: tb/tb_sdr_burst_seq.sv
`timescale 1ns/1ps
module tb_sdr_burst_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startReq;
  logic [20:0] lineAddr;
  logic        fillMode, csSel, rcdSel, trpSel;
  logic [1:0]  casLatA, casLatB;
  logic [1:0]  cmd;
  logic [11:0] rowAddr;
  logic [8:0]  colAddr;
  logic        busStart, dataStrobe, done;

  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;

  sdr_burst_seq dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lineAddr(lineAddr),
    .fillMode(fillMode), .csSel(csSel), .rcdSel(rcdSel),
    .casLatA(casLatA), .casLatB(casLatB), .trpSel(trpSel),
    .cmd(cmd), .rowAddr(rowAddr), .colAddr(colAddr),
    .busStart(busStart), .dataStrobe(dataStrobe), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int tapLen(input int cl, input bit trp);
    if (cl == 1) return trp ? 2 : 1;
    return trp ? 1 : 0;
  endfunction

  function automatic int startBeat(input bit fill, input logic [20:0] a);
    return fill ? ((int'(a[3:1]) + 2) % 8) : 0;
  endfunction

  task automatic scramble();
    lineAddr = 21'($urandom);
    fillMode = 1'($urandom);
    csSel    = 1'($urandom);
    rcdSel   = 1'($urandom);
    trpSel   = 1'($urandom);
    casLatA  = 2'($urandom);
    casLatB  = 2'($urandom);
  endtask

  task automatic runBurst(input bit fill, input bit cs, input bit rcd,
                          input logic [1:0] cla, input logic [1:0] clb,
                          input bit trp, input logic [20:0] addr, input bit holdReq);
    int cl, tc, td1, tdLast, doneK, beat;
    logic [1:0] expCmd;
    logic [8:0] expCol;
    @(negedge clk);
    fillMode = fill; csSel = cs; rcdSel = rcd; casLatA = cla; casLatB = clb;
    trpSel = trp; lineAddr = addr; startReq = 1'b1;
    cl     = int'(cs ? clb : cla) + 1;          // R3 field encoding
    tc     = 2 + int'(rcd);                     // R2
    td1    = tc + cl;
    tdLast = td1 + 7;                           // R4
    doneK  = tdLast + tapLen(cl, trp) + 1;      // R5 R8
    for (int k = 1; k <= doneK + 1; k++) begin
      @(negedge clk);
      expCmd = (k == 1) ? 2'b01 : (k == tc) ? 2'b10 : 2'b00;
      check(cmd == expCmd, "R1 R2 R5 cmd", cmd, expCmd);
      check(dataStrobe == (k >= td1 && k <= tdLast), "R4 dataStrobe", dataStrobe, (k >= td1 && k <= tdLast));
      check(busStart == (k >= td1 && k <= tdLast), "R4 busStart", busStart, (k >= td1 && k <= tdLast));
      check(done == (k == doneK), "R8 done", done, (k == doneK));
      if (k <= doneK)
        check(rowAddr == addr[20:9], "R1 R9 rowAddr", rowAddr, addr[20:9]);
      if (k >= tc && k <= tdLast) begin
        beat   = (k < td1) ? startBeat(fill, addr) : (startBeat(fill, addr) + k - td1) % 8;
        expCol = {addr[8:4], 3'(beat), 1'b0};
        check(colAddr == expCol, "R6 R7 colAddr", colAddr, expCol);
      end
      // R9: drop request only at done when holding; scramble inputs mid-burst
      if (!holdReq || k == doneK) startReq = 1'b0;
      if (k < doneK) scramble();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; startReq = 1'b0;
    lineAddr = '0; fillMode = 0; csSel = 0; rcdSel = 0; trpSel = 0;
    casLatA = 0; casLatB = 0;
    repeat (3) @(negedge clk);
    startReq = 1'b1;   // R10: ignored under reset
    @(negedge clk);
    check(cmd == 2'b00 && !busStart && !dataStrobe && !done, "R10 reset outputs",
          {cmd, busStart, dataStrobe, done}, 0);
    startReq = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(cmd == 2'b00 && !busStart && !dataStrobe && !done, "R10 after reset",
          {cmd, busStart, dataStrobe, done}, 0);

    // directed: every latency, both spaces, both delays, both recovery settings
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 2; r++)
        for (int t = 0; t < 2; t++) begin
          runBurst(1'b0, 1'b0, r[0], 2'(c), 2'(3 - c), t[0], 21'h0A5A3E, 1'b0); // R3 space A
          runBurst(1'b1, 1'b1, r[0], 2'(3 - c), 2'(c), t[0], 21'h1F3F0C, 1'b1); // R3 space B
        end
    // R7 wrap corners: miss beat 6 and 7, DMA with nonzero offset
    runBurst(1'b1, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 21'h00001C, 1'b0);
    runBurst(1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1, 21'h00001E, 1'b1);
    runBurst(1'b0, 1'b1, 1'b0, 2'd2, 2'd3, 1'b1, 21'h12345E, 1'b0);

    // constrained random
    for (int n = 0; n < 60; n++)
      runBurst(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
               2'($urandom), 1'($urandom), 21'($urandom), 1'($urandom));

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule